// File: doc/BRIEF.md
# Split Dual 8-bit Reload Timer

This block holds two independent 8-bit counters, a low half and a high half. When a half overflows, it reloads from its own reload register. Each half takes its count enable, called a tick, from one of three sources:

- every system clock;
- the system clock divided by twelve;
- an external clock divided by eight. The external clock is first brought into the system clock domain with a two-flop synchronizer and a rising-edge detector.

A single select bit chooses between the two divided sources, and both halves share it. Each half also has its own bit that forces counting on every system clock.

Each half has a sticky overflow flag. The flags combine into one level interrupt request. The high flag always contributes when the interrupt is enabled. The low flag contributes only when its own enable bit is also set.

Software reaches the block through a small register port. A write takes effect on the clock edge where `wr_en` is high. Read data is registered: the register selected by `addr` at one edge appears on `rdata` after that edge.

Top module: `dual_reload_timer`

Register addresses: 0 control, 1 flags, 2 low count, 3 high count, 4 low reload, 5 high reload.

Control bits:

| Bit | Meaning |
|---|---|
| 0 | high run |
| 1 | external select (0 = system clock / 12, 1 = external clock / 8) |
| 2 | low-flag interrupt enable |
| 3 | interrupt enable |
| 4 | low half counts on every system clock |
| 5 | high half counts on every system clock |

Flag bits: bit 0 is the low flag and bit 1 is the high flag.

## Requirements
- R1: After synchronous reset, every register reads back as zero and `irq` is low.
- R2: When control bit 4 is 0 and control bit 1 is 1, the low half advances exactly once for every eight rising edges of `ext_clk`. It does not advance while `ext_clk` is static.
- R3: A tick that finds a counter at 0xFF loads that half's reload value in the same edge and sets that half's flag. The low flag is flags bit 0 and the high flag is flags bit 1.
- R4: The high half counts only while control bit 0 (run) is 1. The low half ignores this bit.
- R5: When a half's fast bit is 1 (bit 4 for low, bit 5 for high), that half advances on every system clock.
- R6: When the fast bit is 0 and control bit 1 is 0, the half advances once every twelve system clocks.
- R7: Writing 0 to a flag bit at address 1 clears that flag. Writing 1 leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is a registered level. It is equal to bit 3 AND (high flag OR (bit 2 AND low flag)), taken one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External clock, no faster than `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
If the external divider or the divide-by-twelve counter is in the wrong phase or has the wrong modulus, the low count read back after a known number of ext edges or clocks is off by one. That shows up at the first read after the burst.

If the run gate is stuck, the high count drifts during a window in which it should hold.

A flag whose clear wins over a same-cycle overflow reads back as zero. The `irq` pin shows the same error one cycle after the flags settle.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd5;

  localparam int unsigned CTRL_W   = 6;
  localparam int unsigned C_RUN    = 0;
  localparam int unsigned C_EXTSEL = 1;
  localparam int unsigned C_LOIE   = 2;
  localparam int unsigned C_IE     = 3;
  localparam int unsigned C_FASTLO = 4;
  localparam int unsigned C_FASTHI = 5;

  localparam int unsigned F_LO = 0;
  localparam int unsigned F_HI = 1;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int unsigned SYS_DIV = 12,
  parameter int unsigned EXT_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  output logic div_tick,
  output logic ext_tick
);
  localparam int unsigned SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  logic [SW-1:0] sys_cnt;
  logic [EW-1:0] ext_cnt;
  logic [2:0]    ext_pipe;   // two synchronizer stages plus previous sample
  logic          ext_rise;

  assign ext_rise = ext_pipe[1] & ~ext_pipe[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_cnt  <= '0;
      div_tick <= 1'b0;
    end else if (sys_cnt == SW'(SYS_DIV - 1)) begin
      sys_cnt  <= '0;
      div_tick <= 1'b1;
    end else begin
      sys_cnt  <= sys_cnt + 1'b1;
      div_tick <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_pipe <= '0;
      ext_cnt  <= '0;
      ext_tick <= 1'b0;
    end else begin
      ext_pipe <= {ext_pipe[1:0], ext_clk};
      ext_tick <= 1'b0;
      if (ext_rise) begin
        if (ext_cnt == EW'(EXT_DIV - 1)) begin
          ext_cnt  <= '0;
          ext_tick <= 1'b1;
        end else begin
          ext_cnt <= ext_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/drt_half.sv
module drt_half #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             ld_cnt,
  input  logic             ld_rld,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] rld,
  output logic             flag,
  output logic             wrap
);
  assign wrap = tick & run & (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_cnt) begin
      cnt <= wdata;
    end else if (wrap) begin
      cnt <= rld;
    end else if (tick && run) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rld <= '0;
    else if (ld_rld) rld <= wdata;
  end

  // hardware set outranks a software clear
  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (wrap)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SYS_DIV = 12,
  parameter int unsigned EXT_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl;
  logic              div_tick, ext_tick;
  logic [CNT_W-1:0]  cnt_q [2];
  logic [CNT_W-1:0]  rld_q [2];
  logic [1:0]        flag_q;
  logic [1:0]        wrap_q;
  logic [CNT_W-1:0]  hi_cnt, hi_rld;
  logic              hi_run, hi_wrap;

  drt_prescaler #(.SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV)) u_pre (
    .clk(clk), .rst(rst), .ext_clk(ext_clk),
    .div_tick(div_tick), .ext_tick(ext_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)                          ctrl <= '0;
    else if (wr_en && addr == A_CTRL) ctrl <= wdata[CTRL_W-1:0];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] CNT_A  = (h == 0) ? A_CNT_LO : A_CNT_HI;
    localparam logic [ADDR_W-1:0] RLD_A  = (h == 0) ? A_RLD_LO : A_RLD_HI;
    localparam int unsigned       FAST_B = (h == 0) ? C_FASTLO : C_FASTHI;
    localparam int unsigned       FLAG_B = (h == 0) ? F_LO : F_HI;

    logic tick_sel, run_sel;
    assign tick_sel = ctrl[FAST_B] ? 1'b1 : (ctrl[C_EXTSEL] ? ext_tick : div_tick);
    assign run_sel  = (h == 0) ? 1'b1 : ctrl[C_RUN];

    drt_half #(.CNT_W(CNT_W)) u_half (
      .clk(clk), .rst(rst),
      .tick(tick_sel), .run(run_sel),
      .ld_cnt(wr_en && addr == CNT_A),
      .ld_rld(wr_en && addr == RLD_A),
      .flag_clr(wr_en && addr == A_FLAG && !wdata[FLAG_B]),
      .wdata(wdata),
      .cnt(cnt_q[h]), .rld(rld_q[h]),
      .flag(flag_q[h]), .wrap(wrap_q[h])
    );
  end

  assign hi_cnt  = cnt_q[1];
  assign hi_rld  = rld_q[1];
  assign hi_run  = ctrl[C_RUN];
  assign hi_wrap = wrap_q[1];

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl[C_IE] & (flag_q[F_HI] | (ctrl[C_LOIE] & flag_q[F_LO]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:   rdata <= CNT_W'(ctrl);
        A_FLAG:   rdata <= CNT_W'(flag_q);
        A_CNT_LO: rdata <= cnt_q[0];
        A_CNT_HI: rdata <= cnt_q[1];
        A_RLD_LO: rdata <= rld_q[0];
        A_RLD_HI: rdata <= rld_q[1];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  hi_cnt,
  input logic [CNT_W-1:0]  hi_rld,
  input logic              hi_run,
  input logic              hi_wrap,
  input logic              flag_hi,
  input logic              flag_lo,
  input logic              div_tick,
  input logic              ext_tick
);
  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag_hi || flag_lo));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && !(wr_en && addr == A_FLAG && !wdata[F_HI])) |=> flag_hi);

  p_wrap_from_max_r3: assert property (@(posedge clk) disable iff (rst)
    hi_wrap |-> (hi_cnt == '1));

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (hi_wrap && !(wr_en && addr == A_CNT_HI)) |=> (hi_cnt == $past(hi_rld)));

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!hi_run && !(wr_en && addr == A_CNT_HI)) |=> $stable(hi_cnt));

  p_div_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);

  p_ext_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ext_tick |=> !ext_tick);
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .hi_cnt(hi_cnt), .hi_rld(hi_rld), .hi_run(hi_run), .hi_wrap(hi_wrap),
  .flag_hi(flag_q[1]), .flag_lo(flag_q[0]),
  .div_tick(div_tick), .ext_tick(ext_tick)
);

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  typedef struct {
    logic [2:0] a;
    int         lo;
    int         hi;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int   checks = 0;
  int   errors = 0;
  exp_t sb_q[$];
  logic rd_req = 1'b0;
  logic rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_reload_timer u_dual_reload_timer (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input int lo, input int hi, input string tag);
    exp_t e;
    e.a = a; e.lo = lo; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
    addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq got %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk);
      ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: pops expected read results as the design returns them
  always @(posedge clk) rd_seen <= rd_req;

  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty got %0h expected none", rdata);
      end else begin
        e = sb_q.pop_front();
        if (int'(rdata) < e.lo || int'(rdata) > e.hi) begin
          errors++;
          $display("FAIL %s addr %0d got %0h expected %0h..%0h", e.tag, e.a, rdata, e.lo, e.hi);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (low count first, before any divided tick)
    rd_expect(3'd2, 0, 0, "R1 cnt_lo");
    rd_expect(3'd3, 0, 0, "R1 cnt_hi");
    rd_expect(3'd4, 0, 0, "R1 rld_lo");
    rd_expect(3'd5, 0, 0, "R1 rld_hi");
    rd_expect(3'd1, 0, 0, "R1 flags");
    rd_expect(3'd0, 0, 0, "R1 ctrl");
    chk_irq(1'b0, "R1");

    // R2 external divide by eight
    wr(3'd0, 8'h02);
    wr(3'd2, 8'hFE);
    wr(3'd4, 8'h40);
    ext_edges(8);
    rd_expect(3'd2, 8'hFF, 8'hFF, "R2 eight edges");
    ext_edges(7);
    rd_expect(3'd2, 8'hFF, 8'hFF, "R2 seven edges");
    ext_edges(1);
    // R3 low reload and flag
    rd_expect(3'd2, 8'h40, 8'h40, "R3 low reload");
    rd_expect(3'd1, 1, 1, "R3 low flag");

    // R8 interrupt masking
    wr(3'd0, 8'h0A);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 low flag masked");
    wr(3'd0, 8'h0E);
    repeat (2) @(negedge clk);
    chk_irq(1'b1, "R8 low flag enabled");

    // R7 clear by zero, set by one ignored
    wr(3'd1, 8'hFE);
    rd_expect(3'd1, 0, 0, "R7 clear low");
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 after clear");
    wr(3'd1, 8'hFF);
    rd_expect(3'd1, 0, 0, "R7 write one no effect");

    // R4 run gates high only, low frozen with static ext_clk
    wr(3'd3, 8'h10);
    wr(3'd0, 8'h2A);
    repeat (5) @(negedge clk);
    rd_expect(3'd3, 8'h10, 8'h10, "R4 high held");
    rd_expect(3'd2, 8'h40, 8'h40, "R2 no ext edges");

    // R3 high overflow with five fast ticks
    wr(3'd3, 8'hFD);
    wr(3'd5, 8'h80);
    wr(3'd0, 8'h2B);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h2A);
    rd_expect(3'd3, 8'h82, 8'h82, "R3 high reload");
    rd_expect(3'd1, 2, 2, "R3 high flag");
    chk_irq(1'b1, "R8 high flag");

    // R7 overflow beats simultaneous clear
    wr(3'd1, 8'h00);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h2B);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h2A);
    rd_expect(3'd3, 8'h81, 8'h81, "R7 count after race");
    rd_expect(3'd1, 2, 2, "R7 set wins");
    wr(3'd1, 8'h00);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R8 all clear");

    // R5 fast low: nineteen ticks
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h00);
    repeat (19) @(negedge clk);
    rd_expect(3'd2, 19, 19, "R5 fast low");

    // R6 divide by twelve over 119 clocks
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    repeat (119) @(negedge clk);
    rd_expect(3'd2, 9, 10, "R6 div12 low");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule